// File: doc/BRIEF.md
# Watchdog Reset and Clock Restart Sequencer

This block turns a watchdog overflow into a chip-wide reset and then brings the chip back up in a fixed order. A watchdog overflow pulse counts only while the reset-mode bit is set. When it counts, the sequencer asserts the system reset, stops the main and ring oscillators, and drives every pin to high impedance. It keeps this state for a fixed number of clock cycles and then releases the reset without outside help. The oscillators then restart, and a stabilization interval of 2^STAB_LOG2 cycles runs while the CPU, peripheral and watchdog clocks stay gated. When that interval ends, the clocks are enabled and the CPU is allowed to run.

The block holds two small registers. The CPU divider select returns to its divide-by-8 default during every system reset. The debug-mode register keeps its value through a watchdog reset and is cleared only by power-on reset. Both registers accept writes only while the CPU runs. The subclock enable is never removed. All counting runs on one free-running reference clock. A state code output shows which phase is active: 0 idle under power-on reset, 1 hold, 2 stabilize, 3 run.

Top module: `wdt_rst_seq`

## Requirements
- R1: An overflow pulse while wdt_rst_mode_i is 0 has no effect: the state and all outputs stay as they were.
- R2: An overflow while wdt_rst_mode_i is 1 sets sys_rst_o from the next cycle on (state code 1). The reset lasts exactly HOLD_CYC cycles and then clears by itself (state code 2).
- R3: main_osc_en_o and ring_osc_en_o are 0 while sys_rst_o is 1, and 1 from reset release onwards.
- R4: sub_osc_en_o is 1 in every state, including reset.
- R5: After reset release, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o and cpu_run_o stay 0 for exactly 2^STAB_LOG2 cycles (state code 2). After that they are 1 (state code 3).
- R6: cpu_div_sel_o selects a division by 2^value. It reads 3 (divide by 8) when the CPU run release rises after any reset.
- R7: pin_hiz_o is 1 exactly while sys_rst_o is 1.
- R8: During a system reset the divider select returns to 3. The debug register dbg_mode_o keeps its value.
- R9: A write with reg_wr_i sets the divider from reg_wdata_i[DIV_W-1:0] when reg_sel_i is 0, or sets the debug register from all of reg_wdata_i when reg_sel_i is 1. Writes take effect only in the run state and are ignored otherwise.
- R10: A qualified overflow during hold or stabilization restarts the sequence with a full-length hold.
- R11: While por_n_i is 0 the state code is 0 (idle, reset asserted) and dbg_mode_o is 0. On the first clock after por_n_i rises the state code is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| wdt_rst_mode_i | input | 1 | 1: an overflow causes a system reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: divider select, 1: debug register |
| reg_wdata_i | input | REG_W | Write data |
| sys_rst_o | output | 1 | System reset |
| main_osc_en_o | output | 1 | Main oscillator enable |
| ring_osc_en_o | output | 1 | Ring oscillator enable |
| sub_osc_en_o | output | 1 | Subclock oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate |
| per_clk_en_o | output | 1 | Peripheral clock gate |
| wdt_clk_en_o | output | 1 | Watchdog clock gate |
| cpu_div_sel_o | output | DIV_W | CPU clock divider select (divide by 2^value) |
| pin_hiz_o | output | 1 | Forces all pins to high impedance |
| cpu_run_o | output | 1 | CPU run release |
| dbg_mode_o | output | REG_W | Debug-mode register, kept through watchdog reset |
| state_o | output | 2 | Phase: 0 idle, 1 hold, 2 stabilize, 3 run |

## Verification
Overflow pulses are driven in four kinds of pattern. Random pulses with the mode bit clear must leave the run state untouched. A single qualified pulse must give exact hold and stabilization lengths. A second pulse at a random point of the hold must show that the hold counter restarts instead of finishing. A pulse at a random point of the stabilization must show that the sequence returns to hold and does not reach run early. The register values written before a reset are compared with those seen during and after it, which separates the divider, which must reset, from the debug register, which must survive. A final power-on reset shows that only power-on reset clears the debug register.

// File: rtl/wrst_pkg.sv
package wrst_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_STAB = 2'd2,
      ST_RUN  = 2'd3
   } wrst_state_e;
endpackage

// File: rtl/wrst_timer.sv
// Shared phase counter: measures the reset hold and the stabilization window.
module wrst_timer #(
   parameter int HOLD_CYC  = 16,
   parameter int STAB_LOG2 = 16
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic clr_i,
   input  logic en_i,
   input  logic stab_sel_i,
   output logic done_o
);
   localparam int HW       = $clog2(HOLD_CYC);
   localparam int CW       = ((HW > STAB_LOG2) ? HW : STAB_LOG2) + 1;
   localparam int STAB_CYC = 2 ** STAB_LOG2;
   localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
   localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)    cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (en_i)   cnt_q <= cnt_q + CW'(1);
   end

   always_comb begin
      if (!en_i)           done_o = 1'b0;
      else if (stab_sel_i) done_o = (cnt_q == STAB_LAST);
      else                 done_o = (cnt_q == HOLD_LAST);
   end

   // R2: the hold count never runs past its terminal value
   a_r2_hold_bound: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (en_i && !stab_sel_i) |-> (cnt_q <= HOLD_LAST));
   // R5: the stabilization count never runs past its terminal value
   a_r5_stab_bound: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (en_i && stab_sel_i) |-> (cnt_q <= STAB_LAST));
endmodule

// File: rtl/wrst_fsm.sv
// Phase sequencer: idle -> hold -> stabilize -> run, restart on qualified overflow.
module wrst_fsm
   import wrst_pkg::*;
(
   input  logic        clk_i,
   input  logic        por_n_i,
   input  logic        wdt_ovf_i,
   input  logic        wdt_rst_mode_i,
   input  logic        done_i,
   output wrst_state_e state_o,
   output logic        clr_o
);
   wrst_state_e state_q, state_d;
   logic        trig;

   assign trig = wdt_ovf_i & wdt_rst_mode_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: state_d = ST_HOLD;
         ST_HOLD: if (trig) state_d = ST_HOLD;
                  else if (done_i) state_d = ST_STAB;
         ST_STAB: if (trig) state_d = ST_HOLD;
                  else if (done_i) state_d = ST_RUN;
         ST_RUN:  if (trig) state_d = ST_HOLD;
         default: state_d = ST_IDLE;
      endcase
   end

   assign clr_o = (state_d != state_q) || trig;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) state_q <= ST_IDLE;
      else          state_q <= state_d;
   end

   assign state_o = state_q;

   a_r1_ignore_unqualified: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (state_q == ST_RUN && !(wdt_ovf_i && wdt_rst_mode_i)) |=> (state_q == ST_RUN));
   a_r10_restart_hold: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (wdt_ovf_i && wdt_rst_mode_i) |=> (state_q == ST_HOLD));
   a_r11_por_to_hold: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (state_q == ST_IDLE) |=> (state_q == ST_HOLD));
   a_r5_run_after_done: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (state_q == ST_RUN && $past(state_q) == ST_STAB) |-> $past(done_i));
endmodule

// File: rtl/wrst_regs.sv
// Divider select (reset by system reset) and debug register (power-on reset only).
module wrst_regs #(
   parameter int          REG_W        = 8,
   parameter int          DIV_W        = 3,
   parameter int unsigned DIV_RST      = 3,
   parameter bit          DIV_WRITABLE = 1'b1
) (
   input  logic             clk_i,
   input  logic             por_n_i,
   input  logic             sys_rst_i,
   input  logic             run_i,
   input  logic             wr_i,
   input  logic             sel_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [DIV_W-1:0] div_q_o,
   output logic [REG_W-1:0] dbg_q_o
);
   localparam logic [DIV_W-1:0] DIV_DEF = DIV_W'(DIV_RST);

   logic wr_ok;
   assign wr_ok = wr_i & run_i;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)           dbg_q_o <= '0;
      else if (wr_ok && sel_i) dbg_q_o <= wdata_i;
   end

   generate
      if (DIV_WRITABLE) begin : g_div_rw
         always_ff @(posedge clk_i or negedge por_n_i) begin
            if (!por_n_i)             div_q_o <= DIV_DEF;
            else if (sys_rst_i)       div_q_o <= DIV_DEF;
            else if (wr_ok && !sel_i) div_q_o <= wdata_i[DIV_W-1:0];
         end
      end else begin : g_div_fixed
         assign div_q_o = DIV_DEF;
      end
   endgenerate

   a_r8_dbg_kept: assert property (@(posedge clk_i) disable iff (!por_n_i)
      sys_rst_i |=> $stable(dbg_q_o));
   a_r8_div_default: assert property (@(posedge clk_i) disable iff (!por_n_i)
      sys_rst_i |=> (div_q_o == DIV_DEF));
   a_r9_no_write_halted: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !run_i |=> $stable(dbg_q_o));
endmodule

// File: rtl/wdt_rst_seq.sv
module wdt_rst_seq
   import wrst_pkg::*;
#(
   parameter int          HOLD_CYC     = 16,
   parameter int          STAB_LOG2    = 16,
   parameter int          REG_W        = 8,
   parameter int          DIV_W        = 3,
   parameter int unsigned DIV_RST      = 3,
   parameter bit          DIV_WRITABLE = 1'b1
) (
   input  logic             clk_i,
   input  logic             por_n_i,
   input  logic             wdt_ovf_i,
   input  logic             wdt_rst_mode_i,
   input  logic             reg_wr_i,
   input  logic             reg_sel_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic             sys_rst_o,
   output logic             main_osc_en_o,
   output logic             ring_osc_en_o,
   output logic             sub_osc_en_o,
   output logic             cpu_clk_en_o,
   output logic             per_clk_en_o,
   output logic             wdt_clk_en_o,
   output logic [DIV_W-1:0] cpu_div_sel_o,
   output logic             pin_hiz_o,
   output logic             cpu_run_o,
   output logic [REG_W-1:0] dbg_mode_o,
   output logic [1:0]       state_o
);
   generate
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("HOLD_CYC must be at least 2");
      end
      if (STAB_LOG2 < 1 || STAB_LOG2 > 30) begin : g_bad_stab
         $error("STAB_LOG2 must lie in 1..30");
      end
      if (DIV_W < 2 || REG_W < DIV_W) begin : g_bad_width
         $error("need DIV_W >= 2 and REG_W >= DIV_W");
      end
      if (DIV_RST >= (1 << DIV_W)) begin : g_bad_div
         $error("DIV_RST does not fit in DIV_W bits");
      end
   endgenerate

   wrst_state_e st;
   logic        cnt_clr, cnt_done, cnt_en, in_rst, running;

   wrst_fsm u_fsm (
      .clk_i          (clk_i),
      .por_n_i        (por_n_i),
      .wdt_ovf_i      (wdt_ovf_i),
      .wdt_rst_mode_i (wdt_rst_mode_i),
      .done_i         (cnt_done),
      .state_o        (st),
      .clr_o          (cnt_clr)
   );

   assign cnt_en  = (st == ST_HOLD) || (st == ST_STAB);
   assign in_rst  = (st == ST_IDLE) || (st == ST_HOLD);
   assign running = (st == ST_RUN);

   wrst_timer #(.HOLD_CYC(HOLD_CYC), .STAB_LOG2(STAB_LOG2)) u_timer (
      .clk_i      (clk_i),
      .por_n_i    (por_n_i),
      .clr_i      (cnt_clr),
      .en_i       (cnt_en),
      .stab_sel_i (st == ST_STAB),
      .done_o     (cnt_done)
   );

   wrst_regs #(
      .REG_W(REG_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST), .DIV_WRITABLE(DIV_WRITABLE)
   ) u_regs (
      .clk_i     (clk_i),
      .por_n_i   (por_n_i),
      .sys_rst_i (in_rst),
      .run_i     (running),
      .wr_i      (reg_wr_i),
      .sel_i     (reg_sel_i),
      .wdata_i   (reg_wdata_i),
      .div_q_o   (cpu_div_sel_o),
      .dbg_q_o   (dbg_mode_o)
   );

   assign sys_rst_o     = in_rst;
   assign main_osc_en_o = !in_rst;
   assign ring_osc_en_o = !in_rst;
   assign sub_osc_en_o  = 1'b1;
   assign cpu_clk_en_o  = running;
   assign per_clk_en_o  = running;
   assign wdt_clk_en_o  = running;
   assign pin_hiz_o     = in_rst;
   assign cpu_run_o     = running;
   assign state_o       = st;

   a_r3_osc_off_in_reset: assert property (@(posedge clk_i) disable iff (!por_n_i)
      sys_rst_o |-> (!main_osc_en_o && !ring_osc_en_o));
   a_r7_hiz_tracks_reset: assert property (@(posedge clk_i) disable iff (!por_n_i)
      pin_hiz_o == sys_rst_o);
   a_r6_div8_at_start: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(cpu_run_o) |-> (cpu_div_sel_o == DIV_W'(DIV_RST)));
   a_r5_gates_off_in_reset: assert property (@(posedge clk_i) disable iff (!por_n_i)
      sys_rst_o |-> !(cpu_clk_en_o || per_clk_en_o || wdt_clk_en_o || cpu_run_o));
endmodule

// File: tb/wdt_rst_seq_tb.sv
`timescale 1ns/1ps
module wdt_rst_seq_tb;
   localparam int HOLD  = 16;
   localparam int STAB  = 65536;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ovf = 1'b0, mode = 1'b0;
   logic       wr = 1'b0, sel = 1'b0;
   logic [7:0] wdata = '0;
   logic       sys_rst, main_en, ring_en, sub_en, cpu_en, per_en, wdt_en, hiz, run;
   logic [2:0] div;
   logic [7:0] dbg;
   logic [1:0] st;

   int total = 0, fails = 0, mism = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   wdt_rst_seq u_dut (
      .clk_i(clk), .por_n_i(por_n), .wdt_ovf_i(ovf), .wdt_rst_mode_i(mode),
      .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
      .sys_rst_o(sys_rst), .main_osc_en_o(main_en), .ring_osc_en_o(ring_en),
      .sub_osc_en_o(sub_en), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
      .wdt_clk_en_o(wdt_en), .cpu_div_sel_o(div), .pin_hiz_o(hiz),
      .cpu_run_o(run), .dbg_mode_o(dbg), .state_o(st)
   );

   // expected output vector from the phase (R3, R4, R5, R7)
   function automatic logic [8:0] exp_outs(input logic [1:0] s);
      logic r, g;
      r = (s == 2'd0) || (s == 2'd1);
      g = (s == 2'd3);
      return {r, !r, !r, 1'b1, g, g, g, r, g};
   endfunction

   function automatic logic [8:0] act_outs();
      return {sys_rst, main_en, ring_en, sub_en, cpu_en, per_en, wdt_en, hiz, run};
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cmp_outs();
      if (act_outs() !== exp_outs(st)) mism++;
   endtask

   task automatic tick();
      @(negedge clk);
      cmp_outs();
   endtask

   task automatic pulse_ovf();
      ovf = 1'b1; mode = 1'b1;
      tick();
      ovf = 1'b0;
   endtask

   // count hold and stabilize cycles from the current negedge until run
   task automatic measure(output int nh, output int ns);
      nh = 0; ns = 0;
      for (int i = 0; i < STAB + 4 * HOLD; i++) begin
         cmp_outs();
         if (st == 2'd1) nh++;
         else if (st == 2'd2) ns++;
         else if (st == 2'd3) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      int nh, ns, k, stay;
      logic [7:0] exp_dbg;
      void'($urandom(32'd2024));

      // power-on reset state
      repeat (3) @(negedge clk);
      chk("R11 state during POR", st, 0);
      chk("R11 dbg during POR", dbg, 0);
      chk("R4 subclock in POR", sub_en, 1);
      chk("R7 pins hi-z in POR", hiz, 1);
      chk("R3 main osc off in POR", main_en, 0);
      por_n = 1'b1;
      @(negedge clk);
      chk("R11 first state after POR", st, 1);
      measure(nh, ns);
      chk("R2 hold length", nh, HOLD);
      chk("R5 stabilize length", ns, STAB);
      chk("R6 divider at run", div, 3);
      chk("R5 cpu run", run, 1);

      // register writes in run
      wr = 1; sel = 1; wdata = 8'hA5; tick();
      sel = 0; wdata = 8'h01; tick();
      wr = 0; tick();
      chk("R9 dbg write", dbg, 8'hA5);
      chk("R9 div write", div, 1);

      // random unqualified overflows plus random debug writes
      exp_dbg = 8'hA5; stay = 1;
      for (int i = 0; i < 40; i++) begin
         ovf = 1'($urandom % 2); mode = 1'b0;
         wr = 1'($urandom % 2); sel = 1'b1; wdata = 8'($urandom);
         if (wr) exp_dbg = wdata;
         tick();
         if (st != 2'd3) stay = 0;
      end
      ovf = 0; wr = 0; wdata = 8'hA5; wr = 1; tick(); wr = 0; tick();
      chk("R1 stays in run", stay, 1);
      chk("R9 random dbg writes", dbg, 8'hA5);
      chk("R1 divider untouched", div, 1);

      // qualified overflow, write attempt in hold, restart in hold
      pulse_ovf();
      chk("R2 reset after overflow", sys_rst, 1);
      wr = 1; sel = 1; wdata = 8'h3C; tick(); wr = 0;
      k = 1 + int'($urandom % 10);
      repeat (k) tick();
      chk("R8 divider default in reset", div, 3);
      chk("R9 write ignored in reset", dbg, 8'hA5);
      pulse_ovf();
      measure(nh, ns);
      chk("R10 restart in hold full length", nh, HOLD);
      chk("R5 stabilize after restart", ns, STAB);
      chk("R8 dbg kept through reset", dbg, 8'hA5);
      chk("R6 divider at run after wdt reset", div, 3);

      // restart during stabilization
      pulse_ovf();
      k = HOLD + 1 + int'($urandom % 200);
      repeat (k - 1) tick();
      chk("R10 in stabilize before restart", st, 2);
      chk("R3 main osc on in stabilize", main_en, 1);
      chk("R7 pins released in stabilize", hiz, 0);
      pulse_ovf();
      chk("R10 back to hold", st, 1);
      repeat (3) tick();
      mode = 1'b0;
      chk("R1 mode bit cleared", st, 1);

      // final power-on reset clears debug register
      por_n = 1'b0;
      @(negedge clk);
      chk("R11 POR clears dbg", dbg, 0);
      chk("R11 POR state", st, 0);
      chk("R3 R4 R5 R7 output vector per cycle", mism, 0);

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule